// File: doc/BRIEF.md
# Multiplexed Segment Frame Serialiser

This block turns a parallel image of LCD segment bits into the three-wire serial stream that a multiplexed segment driver expects: a data line, a shift clock and a load strobe. The image holds one row of segment bits for each common phase. When a frame is started, the block captures the image. For each phase it shifts out a fixed-length record made of the row bits, zero padding and a one-hot common-select word. It then raises the load strobe so the driver can latch the record.

The four phases are sent back to back, with a short gap after each load pulse. The last load pulse opens a long quiet interval before another frame may begin. All widths, timings and counts come from parameters given in system-clock cycles. The defaults suit a 50 MHz clock: a shift clock of about 200 kHz, an idle gap of about 6.7 µs between words, a load pulse of about 9.3 µs and a frame gap of about 31.4 ms.

Top module: `segframe_tx`

## Requirements
- R1: Each phase produces exactly 88 rising edges of `serClk` (11 words of 8 bits) before its load pulse, and `serData` is sampled on the rising edge.
- R2: In phase p (p = 0..3), the first 17 bits sent are `segImage[p*17+16]` down to `segImage[p*17]`, in that order. Every later bit of words 1 to 10 is 0.
- R3: The last word of phase p is three 0 bits followed by a one-hot select. Its value is 0x10, 0x08, 0x04 and 0x02 for p = 0, 1, 2 and 3, sent most significant bit first, in that phase order.
- R4: `serClk` is high for CLK_HIGH cycles per bit. Inside a word it is low for CLK_LOW cycles before each bit. It stays low whenever `serLoad` is high.
- R5: Between the last bit of one word and the first bit of the next word, `serClk` stays low for BYTE_GAP + CLK_LOW cycles.
- R6: `serLoad` goes high in the cycle after the 88th clock mark ends. It stays high for LOAD_WIDTH cycles.
- R7: `serData` changes only while `serClk` is low. It is 0 outside bit periods, including during the load pulse.
- R8: A `start` pulse in idle captures `segImage`, and `busy` is high in the following cycle. `busy` falls together with the fourth load pulse. When `start` is held, a new frame begins only after FRAME_GAP cycles of quiet: `busy` is low for FRAME_GAP+1 cycles.
- R9: A `start` pulse that arrives while `busy` is high or during the frame gap is ignored. Changes to `segImage` after capture do not alter the frame being sent.
- R10: During and right after reset, `serData`, `serClk`, `serLoad` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send one frame; accepted only in idle |
| segImage | input | ROW_BITS*PHASES (68) | Segment image; row p occupies bits p*17 and up |
| serData | output | 1 | Serial data, MSB first |
| serClk | output | 1 | Shift clock; the driver samples on the rising edge |
| serLoad | output | 1 | Latch strobe after each phase record |
| busy | output | 1 | High from frame capture until the frame gap begins |

## Verification
Four properties are checked on every cycle:
- the bit, word and phase counters stay in range;
- each freshly loaded record ends in a select word with exactly one bit set;
- `serData` holds steady through each clock mark;
- `busy` only falls on the same edge as the load strobe.

The bench's scenarios are needed for the rest. They show the content and order of the rows and select words and the mark, space, word-gap and load widths. They also cover the discarding of mid-frame and in-gap start requests and the exact length of the frame gap.

// File: rtl/segframe_pkg.sv
package segframe_pkg;

  // Width of the phase index carried in the strobe bundle.
  localparam int PHASE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPACE,
    ST_MARK,
    ST_WGAP,
    ST_LOAD,
    ST_PGAP,
    ST_FGAP
  } ser_state_e;

  typedef struct packed {
    logic               capture;  // grab image, build phase 0 record
    logic               loadRow;  // build record for phase
    logic               shift;    // advance to next bit
    logic [PHASE_W-1:0] phase;
  } dp_strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/segframe_shifter.sv
module segframe_shifter
  import segframe_pkg::*;
#(
  parameter int ROW_BITS  = 17,
  parameter int PHASES    = 4,
  parameter int WORD_BITS = 8,
  parameter int WORDS     = 11,
  parameter int SEL_PAD   = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ROW_BITS*PHASES-1:0] segImage,
  input  dp_strobe_t                 strobes,
  output logic                       dataBit
);

  localparam int FRAME_BITS = WORD_BITS * WORDS;
  localparam int IMG_BITS   = ROW_BITS * PHASES;
  localparam int SEL_TOP    = WORD_BITS - 1 - SEL_PAD;

  logic [IMG_BITS-1:0]   imageReg;
  logic [FRAME_BITS-1:0] shiftReg;

  // Record: row bits first (MSB first), zero padding, then select word.
  function automatic logic [FRAME_BITS-1:0] buildRecord(
    input logic [IMG_BITS-1:0] img,
    input logic [PHASE_W-1:0]  phase
  );
    logic [FRAME_BITS-1:0] rec;
    logic [ROW_BITS-1:0]   row;
    rec = '0;
    row = '0;
    for (int r = 0; r < PHASES; r++) begin
      if (PHASE_W'(r) == phase) row = img[r*ROW_BITS +: ROW_BITS];
    end
    rec[FRAME_BITS-1 -: ROW_BITS] = row;
    for (int k = 0; k < PHASES; k++) begin
      rec[SEL_TOP-k] = (PHASE_W'(k) == phase);
    end
    return rec;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      imageReg <= '0;
      shiftReg <= '0;
    end else if (strobes.capture) begin
      imageReg <= segImage;
      shiftReg <= buildRecord(segImage, '0);
    end else if (strobes.loadRow) begin
      shiftReg <= buildRecord(imageReg, strobes.phase);
    end else if (strobes.shift) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign dataBit = shiftReg[FRAME_BITS-1];

  // R3: every new record carries a single select bit in its last word.
  assert_select_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture || strobes.loadRow) |=>
      ($countones(shiftReg[WORD_BITS-1:0]) == 1));

endmodule

// File: rtl/segframe_sequencer.sv
module segframe_sequencer
  import segframe_pkg::*;
#(
  parameter int WORD_BITS  = 8,
  parameter int WORDS      = 11,
  parameter int PHASES     = 4,
  parameter int CLK_LOW    = 195,
  parameter int CLK_HIGH   = 65,
  parameter int BYTE_GAP   = 335,
  parameter int LOAD_WIDTH = 465,
  parameter int PHASE_GAP  = 800,
  parameter int FRAME_GAP  = 1570000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output dp_strobe_t strobes,
  output logic       serClk,
  output logic       serLoad,
  output logic       dataEn,
  output logic       busy
);

  localparam int LONGEST = maxOf(maxOf(maxOf(CLK_LOW, CLK_HIGH), maxOf(BYTE_GAP, LOAD_WIDTH)),
                                 maxOf(PHASE_GAP, FRAME_GAP));
  localparam int TW  = $clog2(LONGEST + 1);
  localparam int BCW = $clog2(WORD_BITS);
  localparam int WCW = $clog2(WORDS);

  ser_state_e         state, nState;
  logic [TW-1:0]      timer, nTimer;
  logic [BCW-1:0]     bitCnt, nBit;
  logic [WCW-1:0]     wordCnt, nWord;
  logic [PHASE_W-1:0] phaseCnt, nPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      bitCnt   <= '0;
      wordCnt  <= '0;
      phaseCnt <= '0;
    end else begin
      state    <= nState;
      timer    <= nTimer;
      bitCnt   <= nBit;
      wordCnt  <= nWord;
      phaseCnt <= nPhase;
    end
  end

  always_comb begin
    nState  = state;
    nTimer  = (timer != '0) ? timer - TW'(1) : timer;
    nBit    = bitCnt;
    nWord   = wordCnt;
    nPhase  = phaseCnt;
    strobes = '0;
    strobes.phase = phaseCnt;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.capture = 1'b1;
          nState = ST_SPACE;
          nTimer = TW'(CLK_LOW - 1);
          nBit   = '0;
          nWord  = '0;
          nPhase = '0;
        end
      end
      ST_SPACE: begin
        if (timer == '0) begin
          nState = ST_MARK;
          nTimer = TW'(CLK_HIGH - 1);
        end
      end
      ST_MARK: begin
        if (timer == '0) begin
          strobes.shift = 1'b1;
          if (bitCnt == BCW'(WORD_BITS - 1)) begin
            nBit = '0;
            if (wordCnt == WCW'(WORDS - 1)) begin
              nWord  = '0;
              nState = ST_LOAD;
              nTimer = TW'(LOAD_WIDTH - 1);
            end else begin
              nWord  = wordCnt + WCW'(1);
              nState = ST_WGAP;
              nTimer = TW'(BYTE_GAP - 1);
            end
          end else begin
            nBit   = bitCnt + BCW'(1);
            nState = ST_SPACE;
            nTimer = TW'(CLK_LOW - 1);
          end
        end
      end
      ST_WGAP: begin
        if (timer == '0) begin
          nState = ST_SPACE;
          nTimer = TW'(CLK_LOW - 1);
        end
      end
      ST_LOAD: begin
        if (timer == '0) begin
          if (phaseCnt == PHASE_W'(PHASES - 1)) begin
            nPhase = '0;
            nState = ST_FGAP;
            nTimer = TW'(FRAME_GAP - 1);
          end else begin
            nPhase = phaseCnt + PHASE_W'(1);
            nState = ST_PGAP;
            nTimer = TW'(PHASE_GAP - 1);
          end
        end
      end
      ST_PGAP: begin
        if (timer == '0) begin
          strobes.loadRow = 1'b1;
          nState = ST_SPACE;
          nTimer = TW'(CLK_LOW - 1);
        end
      end
      ST_FGAP: begin
        if (timer == '0) nState = ST_IDLE;
      end
      default: nState = ST_IDLE;
    endcase
  end

  assign serClk  = (state == ST_MARK);
  assign serLoad = (state == ST_LOAD);
  assign dataEn  = (state == ST_SPACE) || (state == ST_MARK);
  assign busy    = (state != ST_IDLE) && (state != ST_FGAP);

  // R1: position counters never leave their record geometry.
  assert_counters_bounded_R1: assert property (@(posedge clk) disable iff (!rstN)
    (int'(bitCnt) < WORD_BITS) && (int'(wordCnt) < WORDS) && (int'(phaseCnt) < PHASES));

endmodule

// File: rtl/segframe_tx.sv
module segframe_tx
  import segframe_pkg::*;
#(
  parameter int ROW_BITS   = 17,
  parameter int PHASES     = 4,
  parameter int WORD_BITS  = 8,
  parameter int WORDS      = 11,
  parameter int SEL_PAD    = 3,
  parameter int CLK_LOW    = 195,
  parameter int CLK_HIGH   = 65,
  parameter int BYTE_GAP   = 335,
  parameter int LOAD_WIDTH = 465,
  parameter int PHASE_GAP  = 800,
  parameter int FRAME_GAP  = 1570000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [ROW_BITS*PHASES-1:0] segImage,
  output logic                       serData,
  output logic                       serClk,
  output logic                       serLoad,
  output logic                       busy
);

  dp_strobe_t strobes;
  logic       dataBit;
  logic       dataEn;

  segframe_sequencer #(
    .WORD_BITS(WORD_BITS), .WORDS(WORDS), .PHASES(PHASES),
    .CLK_LOW(CLK_LOW), .CLK_HIGH(CLK_HIGH), .BYTE_GAP(BYTE_GAP),
    .LOAD_WIDTH(LOAD_WIDTH), .PHASE_GAP(PHASE_GAP), .FRAME_GAP(FRAME_GAP)
  ) i_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .strobes(strobes),
    .serClk(serClk), .serLoad(serLoad), .dataEn(dataEn), .busy(busy)
  );

  segframe_shifter #(
    .ROW_BITS(ROW_BITS), .PHASES(PHASES), .WORD_BITS(WORD_BITS),
    .WORDS(WORDS), .SEL_PAD(SEL_PAD)
  ) i_shifter (
    .clk(clk), .rstN(rstN), .segImage(segImage), .strobes(strobes), .dataBit(dataBit)
  );

  assign serData = dataBit & dataEn;

  // R7: data is frozen across a clock mark.
  assert_data_stable_mark_R7: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serData));

  // R8: busy drops only as the last load pulse ends.
  assert_busy_ends_with_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $fell(serLoad));

endmodule

// File: tb/test_segframe_tx.sv
module test_segframe_tx;

  localparam int ROWB = 17, PH = 4, CL = 3, CH = 2, BG = 4, LW = 3, PG = 5, FG = 30;
  localparam int IMGB = ROWB * PH;
  localparam int FB   = 88;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [IMGB-1:0] segImage = '0;
  logic            serData, serClk, serLoad, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [FB-1:0] expQ[$];

  segframe_tx #(
    .CLK_LOW(CL), .CLK_HIGH(CH), .BYTE_GAP(BG), .LOAD_WIDTH(LW),
    .PHASE_GAP(PG), .FRAME_GAP(FG)
  ) i_segframe_tx (
    .clk(clk), .rstN(rstN), .start(start), .segImage(segImage),
    .serData(serData), .serClk(serClk), .serLoad(serLoad), .busy(busy)
  );

  always #2ns clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected record for phase p, built from the requirement text (R2, R3).
  function automatic logic [FB-1:0] expRecord(input logic [IMGB-1:0] img, input int p);
    logic [FB-1:0] w;
    w = '0;
    for (int b = 0; b < ROWB; b++) w[FB-1-b] = img[p*ROWB + ROWB-1 - b];
    w[7:0] = 8'h10 >> p;
    return w;
  endfunction

  task automatic pushFrame(input logic [IMGB-1:0] img);
    for (int p = 0; p < PH; p++) expQ.push_back(expRecord(img, p));
  endtask

  task automatic pulseStart(input logic [IMGB-1:0] img);
    pushFrame(img);
    @(negedge clk);
    segImage = img;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", busy, 1);
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  logic          prevClk = 0, prevLoad = 0, prevData = 0;
  logic [FB-1:0] rxWord = '0;
  int bitsSeen = 0, lowRun = 0, highRun = 0, loadRun = 0, phaseSeen = 0;
  int clkInLoad = 0, dataGlitch = 0, riseTotal = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (serLoad && serClk) clkInLoad++;
      if (serClk && prevClk && serData != prevData) dataGlitch++;
      if (serLoad && serData) dataGlitch++;

      if (serClk && !prevClk) begin
        riseTotal++;
        if (bitsSeen > 0) begin
          if (bitsSeen % 8 == 0)
            check(lowRun == CL + BG, "R5 low time between words", lowRun, CL + BG);
          else
            check(lowRun == CL, "R4 clock space", lowRun, CL);
        end
        rxWord   = {rxWord[FB-2:0], serData};
        bitsSeen++;
        lowRun  = 0;
        highRun = 1;
      end else if (!serClk && prevClk) begin
        check(highRun == CH, "R4 clock mark", highRun, CH);
        highRun = 0;
        lowRun  = 1;
      end else if (serClk) begin
        highRun++;
      end else begin
        lowRun++;
      end

      if (serLoad && !prevLoad) begin
        logic [FB-1:0] e;
        check(bitsSeen == FB, "R1 bits per phase", bitsSeen, FB);
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected phase", rxWord, 0);
        end else begin
          e = expQ.pop_front();
          check(rxWord[FB-1 -: ROWB] == e[FB-1 -: ROWB], "R2 row bits",
                rxWord[FB-1 -: ROWB], e[FB-1 -: ROWB]);
          check(rxWord[FB-ROWB-1:8] == '0, "R2 zero padding", rxWord[FB-ROWB-1:8], 0);
          check(rxWord[7:0] == e[7:0], "R3 select word", rxWord[7:0], e[7:0]);
        end
        bitsSeen = 0;
        rxWord   = '0;
        loadRun  = 1;
      end else if (serLoad) begin
        loadRun++;
      end else if (prevLoad) begin
        check(loadRun == LW, "R6 load width", loadRun, LW);
        phaseSeen++;
        if (phaseSeen % PH == 0)
          check(busy == 1'b0, "R8 busy low after last load", busy, 0);
        else
          check(busy == 1'b1, "R8 busy between phases", busy, 1);
      end

      prevClk  = serClk;
      prevLoad = serLoad;
      prevData = serData;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [IMGB-1:0] imgA, imgB, imgC;
    int n, rises;
    imgA = '1;
    imgB = 68'h1_2345_6789_ABCD_EF01;
    imgC = '0;

    // R10: reset state
    repeat (3) @(negedge clk);
    check({serData, serClk, serLoad, busy} == 4'b0, "R10 outputs in reset",
          {serData, serClk, serLoad, busy}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({serData, serClk, serLoad, busy} == 4'b0, "R10 outputs after reset",
          {serData, serClk, serLoad, busy}, 0);

    // Frame with all segments on (R1, R2, R3)
    pulseStart(imgA);
    waitIdle();
    check(expQ.size() == 0, "R1 all phases of frame A seen", expQ.size(), 0);

    // R9: start during the frame gap is ignored
    repeat (5) @(negedge clk);
    rises = riseTotal;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R9 start in gap ignored (busy)", busy, 0);
    check(riseTotal == rises, "R9 start in gap ignored (clock)", riseTotal, rises);
    repeat (FG + 5) @(negedge clk);

    // Mixed pattern; start and new image mid-frame must be ignored (R9)
    pulseStart(imgB);
    repeat (60) @(negedge clk);
    segImage = ~imgB;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy kept during mid-frame start", busy, 1);
    waitIdle();
    check(expQ.size() == 0, "R9 frame B complete with captured image", expQ.size(), 0);

    // R8: held start waits out the full frame gap; zero image (R2)
    pushFrame(imgC);
    segImage = imgC;
    start = 1'b1;
    n = 1;
    forever begin
      @(negedge clk);
      if (busy) break;
      n++;
    end
    start = 1'b0;
    check(n == FG + 1, "R8 frame gap length", n, FG + 1);
    waitIdle();
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 zero frame complete", expQ.size(), 0);

    check(clkInLoad == 0, "R4 clock low during load", clkInLoad, 0);
    check(dataGlitch == 0, "R7 data change only while clock low", dataGlitch, 0);
    check(phaseSeen == 3 * PH, "R1 phase count over three frames", phaseSeen, 3 * PH);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule